// File: doc/BRIEF.md
# Quarter-Wave Subcarrier Sine/Cosine Generator

This block turns a subcarrier phase word into a pair of signed sine and cosine samples for a colour demodulator. Only a quarter of a cycle is stored: the low bits of the phase address a lookup table, and the two top bits name the quadrant. The quadrant decides how the table's two magnitudes are swapped and negated to rebuild the full-cycle waveforms.

The table is filled at elaboration from a function whose sample points sit half a step into each phase interval. Because of that offset, the values at mirrored points match exactly, and no sample lands on a zero crossing.

Line-alternating colour standards also reverse the V axis on every other line. For these standards, a line-parity input inverts the cosine output while a mode input is high. The pipeline advances only on cycles with the sample enable high, and the outputs are registered.

Top module: `qsc_gen`

## Requirements
- R1: Two enabled cycles after phase p (0..2047) is presented, `sin_o` equals round(2047·sin(2π(p+0.5)/2048)), to within one LSB. It is positive for p < 1024.
- R2: With the V-axis flip inactive, `cos_o` equals round(2047·cos(2π(p+0.5)/2048)), to within one LSB.
- R3: Bits [10:9] of the phase select the quadrant and bits [8:0] the angle inside it. The sine output obeys sin(p+1024) = −sin(p) and sin(1023−p) = sin(p) exactly.
- R4: Sine and cosine come from the same phase sample, and cos(p) equals sin((p+512) mod 2048) exactly.
- R5: Neither output ever leaves the range −2047..+2047, so the value −2048 never appears.
- R6: When `pal_mode` and `pal_line` are both 1 on the enabled cycle that samples a phase, the cosine for that phase is negated. The sine is unchanged.
- R7: When `pal_mode` is 0, `pal_line` has no effect on either output.
- R8: The latency is exactly two enabled cycles. While `en` is 0, every stage and both outputs hold their values.
- R9: While `rst_n` is low, both outputs are cleared to 0, and they remain 0 until two enabled cycles have passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| en | input | 1 | Sample enable; the pipeline advances only when high |
| phase | input | 11 | Subcarrier phase word; [10:9] quadrant, [8:0] angle |
| pal_mode | input | 1 | High for line-alternating standards |
| pal_line | input | 1 | Line parity; inverts the cosine when `pal_mode` is high |
| sin_o | output | 12 | Signed sine sample (U axis) |
| cos_o | output | 12 | Signed cosine sample (V axis) |

## Verification
Some properties are checked by the assertions on every cycle:
- the outputs hold while the enable is low;
- the value −2048 never appears;
- the table stage only ever carries non-negative magnitudes;
- after the first result, the sum of the two output magnitudes stays near full scale, which catches a wrong quadrant fold.

Other properties only the bench's scenarios can show. These are the exact sample values against the closed-form formula over all 2048 phases, the exact mirror and quarter-turn relations, the V-axis inversion, the indifference of the line input when the mode is off, and the two-enabled-cycle latency with enable gaps.

// File: rtl/qsc_pkg.sv
package qsc_pkg;

    typedef enum logic [1:0] {
        QD_0 = 2'd0,
        QD_1 = 2'd1,
        QD_2 = 2'd2,
        QD_3 = 2'd3
    } quad_e;

    // Magnitude of one table point, rounded to nearest; half-step phase offset.
    function automatic int qtr_entry(input int idx, input int qtr_n,
                                     input int amp_max, input bit want_cos);
        real ang;
        real val;
        ang = (real'(idx) + 0.5) * 1.5707963267948966 / real'(qtr_n);
        val = real'(amp_max) * (want_cos ? $cos(ang) : $sin(ang));
        return $rtoi(val + 0.5);
    endfunction

endpackage

// File: rtl/qsc_rom.sv
module qsc_rom
    import qsc_pkg::*;
#(
    parameter int QTR_W = 9,
    parameter int AMP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [QTR_W-1:0] addr,
    input  quad_e            quad_i,
    input  logic             flip_i,
    output logic [AMP_W-1:0] sin_mag,
    output logic [AMP_W-1:0] cos_mag,
    output quad_e            quad_o,
    output logic             flip_o
);
    localparam int QTR_N   = 1 << QTR_W;
    localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;

    typedef struct packed {
        logic [AMP_W-1:0] s;
        logic [AMP_W-1:0] c;
        quad_e            quad;
        logic             flip;
    } rd_t;

    logic [2*AMP_W-1:0] tbl [QTR_N];

    for (genvar gi = 0; gi < QTR_N; gi++) begin : g_tbl
        assign tbl[gi] = {AMP_W'(qtr_entry(gi, QTR_N, AMP_MAX, 1'b1)),
                          AMP_W'(qtr_entry(gi, QTR_N, AMP_MAX, 1'b0))};
    end

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (en) begin
            rd_d.c    = tbl[addr][2*AMP_W-1:AMP_W];
            rd_d.s    = tbl[addr][AMP_W-1:0];
            rd_d.quad = quad_i;
            rd_d.flip = flip_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '{s: '0, c: '0, quad: QD_0, flip: 1'b0};
        end else begin
            rd_q <= rd_d;
        end
    end

    assign sin_mag = rd_q.s;
    assign cos_mag = rd_q.c;
    assign quad_o  = rd_q.quad;
    assign flip_o  = rd_q.flip;

    // R5: table magnitudes carried to the fold stage are never negative
    a_r5_mag_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        !sin_mag[AMP_W-1] && !cos_mag[AMP_W-1]);

endmodule

// File: rtl/qsc_fold.sv
module qsc_fold
    import qsc_pkg::*;
#(
    parameter int AMP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [AMP_W-1:0]        sin_mag,
    input  logic [AMP_W-1:0]        cos_mag,
    input  quad_e                   quad,
    input  logic                    flip,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o
);
    localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;

    typedef struct packed {
        logic signed [AMP_W-1:0] s;
        logic signed [AMP_W-1:0] c;
    } out_t;

    out_t out_d, out_q;
    logic signed [AMP_W-1:0] sm, cm;

    assign sm = $signed(sin_mag);
    assign cm = $signed(cos_mag);

    always_comb begin
        out_d = out_q;
        if (en) begin
            unique case (quad)
                QD_0: begin out_d.s =  sm; out_d.c =  cm; end
                QD_1: begin out_d.s =  cm; out_d.c = -sm; end
                QD_2: begin out_d.s = -sm; out_d.c = -cm; end
                default: begin out_d.s = -cm; out_d.c =  sm; end
            endcase
            if (flip) begin
                out_d.c = -out_d.c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sin_o = out_q.s;
    assign cos_o = out_q.c;

    logic [AMP_W:0] abs_sum;
    assign abs_sum = {1'b0, (sin_o < 0) ? -sin_o : sin_o}
                   + {1'b0, (cos_o < 0) ? -cos_o : cos_o};

    // R3: once a result exists, the quadrant fold keeps |sin|+|cos| near full scale
    a_r3_fold_amplitude: assert property (@(posedge clk) disable iff (!rst_n)
        (sin_o != 0 || cos_o != 0) |-> (abs_sum >= (AMP_W+1)'(AMP_MAX - 2)));

endmodule

// File: rtl/qsc_gen.sv
module qsc_gen
    import qsc_pkg::*;
#(
    parameter int PHASE_W = 11,
    parameter int AMP_W   = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [PHASE_W-1:0]      phase,
    input  logic                    pal_mode,
    input  logic                    pal_line,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o
);
    localparam int QTR_W = PHASE_W - 2;

    logic [AMP_W-1:0] s_mag, c_mag;
    quad_e            quad_q;
    logic             flip_q;

    qsc_rom #(.QTR_W(QTR_W), .AMP_W(AMP_W)) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .addr    (phase[QTR_W-1:0]),
        .quad_i  (quad_e'(phase[PHASE_W-1:QTR_W])),
        .flip_i  (pal_mode & pal_line),
        .sin_mag (s_mag),
        .cos_mag (c_mag),
        .quad_o  (quad_q),
        .flip_o  (flip_q)
    );

    qsc_fold #(.AMP_W(AMP_W)) u_fold (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .sin_mag (s_mag),
        .cos_mag (c_mag),
        .quad    (quad_q),
        .flip    (flip_q),
        .sin_o   (sin_o),
        .cos_o   (cos_o)
    );

    // R8: a disabled cycle leaves both outputs untouched
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(sin_o) && $stable(cos_o)));

    // R5: the most negative code never reaches the outputs
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (sin_o != {1'b1, {(AMP_W-1){1'b0}}}) && (cos_o != {1'b1, {(AMP_W-1){1'b0}}}));

endmodule

// File: tb/qsc_gen_test.sv
module qsc_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NPH = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [10:0] phase = '0;
    logic pal_mode = 1'b0;
    logic pal_line = 1'b0;
    logic signed [11:0] sin_o, cos_o;

    int checks = 0;
    int errors = 0;
    int s_base [NPH];
    int c_base [NPH];

    always #(CLK_PERIOD/2) clk = ~clk;

    qsc_gen uut (
        .clk(clk), .rst_n(rst_n), .en(en), .phase(phase),
        .pal_mode(pal_mode), .pal_line(pal_line),
        .sin_o(sin_o), .cos_o(cos_o)
    );

    function automatic int ref_val(input int p, input bit want_cos);
        real a, x;
        a = 6.283185307179586 * (real'(p) + 0.5) / 2048.0;
        x = 2047.0 * (want_cos ? $cos(a) : $sin(a));
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    task automatic check(input string req, input int act, input int exp, input int tol);
        int d;
        checks++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // kind 0: record base; 1: V flip expected; 2: must equal base
    task automatic sweep(input int kind);
        for (int i = 0; i < NPH + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                int p;
                p = i - 2;
                if (kind == 0) begin
                    s_base[p] = int'(sin_o);
                    c_base[p] = int'(cos_o);
                    check("R1 sine value", int'(sin_o), ref_val(p, 1'b0), 1);
                    check("R2 cosine value", int'(cos_o), ref_val(p, 1'b1), 1);
                end else if (kind == 1) begin
                    check("R6 cosine negated", int'(cos_o), -c_base[p], 0);
                    check("R6 sine unchanged", int'(sin_o), s_base[p], 0);
                end else begin
                    check("R7 cosine unaffected", int'(cos_o), c_base[p], 0);
                    check("R7 sine unaffected", int'(sin_o), s_base[p], 0);
                end
            end
            if (i < NPH) phase = 11'(i);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset sine", int'(sin_o), 0, 0);
        check("R9 reset cosine", int'(cos_o), 0, 0);

        en = 1'b1;
        sweep(0);

        for (int p = 0; p < 1024; p++)
            check("R3 half-turn sign", s_base[p + 1024], -s_base[p], 0);
        for (int p = 0; p < 512; p++)
            check("R3 quadrant mirror", s_base[1023 - p], s_base[p], 0);
        for (int p = 0; p < NPH; p++)
            check("R4 quarter-turn pair", c_base[p], s_base[(p + 512) % NPH], 0);
        for (int p = 0; p < NPH; p++) begin
            checks++;
            if (s_base[p] < -2047 || s_base[p] > 2047 || c_base[p] < -2047 || c_base[p] > 2047) begin
                errors++;
                $display("FAIL R5 range: actual %0d/%0d expected within 2047", s_base[p], c_base[p]);
            end
        end

        @(negedge clk);
        pal_mode = 1'b1; pal_line = 1'b1;
        sweep(1);
        @(negedge clk);
        pal_mode = 1'b0; pal_line = 1'b1;
        sweep(2);
        pal_line = 1'b0;

        // R8 latency and hold with enable gaps
        @(negedge clk);
        phase = 11'd100; en = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 steady sine", int'(sin_o), s_base[100], 0);
        phase = 11'd700;
        @(negedge clk);
        check("R8 one edge sine", int'(sin_o), s_base[100], 0);
        check("R8 one edge cosine", int'(cos_o), c_base[100], 0);
        en = 1'b0; phase = 11'd1500;
        repeat (3) @(negedge clk);
        check("R8 hold sine", int'(sin_o), s_base[100], 0);
        check("R8 hold cosine", int'(cos_o), c_base[100], 0);
        en = 1'b1;
        @(negedge clk);
        check("R8 second edge sine", int'(sin_o), s_base[700], 0);
        check("R8 second edge cosine", int'(cos_o), c_base[700], 0);
        @(negedge clk);
        check("R8 follow-on sine", int'(sin_o), s_base[1500], 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule